// File: doc/BRIEF.md
# Multiplexed Address/Data Flash Read Front End

This block is the slave side of a 16-bit flash bus on which address and data share the same wires. The host places an address on the bus and raises the address-valid strobe. The block captures the address and, in the same clock, loads a four-word page from its internal array model. While chip enable and output enable are both asserted, it drives the addressed word of that page back onto the bus.

A write cycle on the bus carries a command byte. Commands switch between array reads and an identifier mode, and they set the protect and lock bits of the block that the latched address points into. In identifier mode the block returns a manufacturer code, a device code or a two-bit protection status instead of array data. Clearing protection on a locked block requires the write-protect pin to be released.

All pins are sampled on the system clock. The bus is modelled as separate input, output and output-enable vectors, and a pad ring turns these into a tri-state pin.

Top module: `flash_mux_rd`

## Requirements
- R1: The address is taken from `ad_i[AW-1:0]` (AW = 10 by default) on a clock where `adv_n` is sampled 1, was 0 at the previous clock, and `ce_n` is 0. Bus bits above AW are not used. A strobe rise while `ce_n` is 1 does not change the latched address.
- R2: The array word at address a is the low 16 bits of (a × 40503), XOR 16'h5A3C.
- R3: In array mode the output is the word at the latched address. Each latch loads the whole 4-word page `{a[AW-1:2], 0..3}`, and `a[1:0]` selects the word. The word appears on `ad_o` at the clock edge after the enable condition is sampled.
- R4: `ad_oe` becomes 1 at the edge after `ce_n`=0, `oe_n`=0 and `pwrdn_n`=1 are sampled with `rst`=0. Otherwise it becomes 0. Whenever `ad_oe` is 0, `ad_o` is 0.
- R5: In identifier mode, address offset `a[1:0]` gives the output: 0 returns 16'h0020, 1 returns DEV_ID (default 16'h7E41), and 3 returns 16'h0000. None of these values comes from the page buffer.
- R6: In identifier mode, offset 2 returns the status of block `a[9:7]`, with bit0 = protected and bit1 = locked. The possible values are 0000h, 0001h, 0002h and 0003h.
- R7: A command is accepted on a clock where `we_n` is sampled 0 after 1, with `ce_n`=0, `oe_n`=1 and `pwrdn_n`=1. The command code is `ad_i[7:0]`: FFh selects array mode, 90h selects identifier mode, 01h protects the latched block, D0h unprotects it, and 2Fh locks it. Any other code has no effect.
- R8: An unprotect command clears the protect bit of a locked block only when `wprot_n`=1. Unlocked blocks are unprotected regardless of `wprot_n`.
- R9: No command clears a lock bit.
- R10: While `rst`=1 or `pwrdn_n`=0, the block ignores all other inputs and the bus is released. When it leaves this state, every block is protected and unlocked, array mode is selected, and the latched address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| adv_n | input | 1 | Address-valid strobe; rising edge latches the address |
| pwrdn_n | input | 1 | Reset/power-down pin, active low |
| wprot_n | input | 1 | Write-protect pin, active low |
| ad_i | input | 16 | Shared bus, inbound value |
| ad_o | output | 16 | Shared bus, outbound value |
| ad_oe | output | 1 | Bus drive enable |

## Verification
Array reads are tried at all four offsets within one page, at an address whose bus bits above the array width are set, and after a strobe rise with chip enable off. Together these separate word selection, page loading, truncation of the upper address bits and gating of the latch by chip enable. Identifier reads cover each offset. The status of one block is stepped through lock, unprotect with write protect asserted and with it released, re-protect and unknown codes. A second, unlocked block is then unprotected with write protect asserted, which separates lock-gated behaviour from plain unprotect. A power-down pulse taken with the bus enabled shows the release of the bus and the restored status and mode.

// File: rtl/flash_mux_pkg.sv
`timescale 1ns/1ps
package flash_mux_pkg;

  typedef enum logic {
    MODE_ARRAY = 1'b0,
    MODE_IDENT = 1'b1
  } rd_mode_e;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_IDENT      = 8'h90;
  localparam logic [7:0] CMD_PROTECT    = 8'h01;
  localparam logic [7:0] CMD_UNPROTECT  = 8'hD0;
  localparam logic [7:0] CMD_LOCK       = 8'h2F;

  // Fixed content pattern of the array model (R2)
  function automatic logic [15:0] array_word(input logic [31:0] addr);
    logic [31:0] prod;
    prod = addr * 32'd40503;
    return prod[15:0] ^ 16'h5A3C;
  endfunction

endpackage

// File: rtl/fmx_bus_sampler.sv
`timescale 1ns/1ps
module fmx_bus_sampler #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_any,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] lat_addr,
  output logic          lat_stb,
  output logic          cmd_stb
);

  logic adv_q;
  logic we_q;

  // Edge detection against the previous sampled pin level
  assign lat_stb = adv_n & ~adv_q & ~ce_n;
  assign cmd_stb = ~we_n & we_q & ~ce_n & oe_n;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      adv_q    <= 1'b1;
      we_q     <= 1'b1;
      lat_addr <= '0;
    end else begin
      adv_q <= adv_n;
      we_q  <= we_n;
      if (lat_stb) begin
        lat_addr <= addr_in;
      end
    end
  end

endmodule

// File: rtl/fmx_page_store.sv
`timescale 1ns/1ps
module fmx_page_store
  import flash_mux_pkg::*;
#(
  parameter int AW         = 10,
  parameter int BUS_W      = 16,
  parameter int PAGE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst_any,
  input  logic                         ld,
  input  logic [AW-$clog2(PAGE_WORDS)-1:0] ld_page,
  input  logic [$clog2(PAGE_WORDS)-1:0]    sel,
  output logic [BUS_W-1:0]             word_out
);

  localparam int OFS_W  = $clog2(PAGE_WORDS);
  localparam int PG_W   = AW - OFS_W;
  localparam int PAGES  = 1 << PG_W;
  localparam int LINE_W = PAGE_WORDS * BUS_W;

  logic [LINE_W-1:0] mem [PAGES];
  logic [LINE_W-1:0] page_q;
  logic [BUS_W-1:0]  words [PAGE_WORDS];
  logic [PG_W-1:0]   rd_page;
  logic              rd_en;

  // Array model contents, one full page per memory line
  initial begin
    for (int p = 0; p < PAGES; p++) begin
      for (int w = 0; w < PAGE_WORDS; w++) begin
        mem[p][w*BUS_W +: BUS_W] = BUS_W'(array_word(32'(p * PAGE_WORDS + w)));
      end
    end
  end

  // Reset reloads page 0 so the buffer matches the cleared address
  assign rd_en   = ld | rst_any;
  assign rd_page = rst_any ? '0 : ld_page;

  always_ff @(posedge clk) begin
    if (rd_en) begin
      page_q <= mem[rd_page];
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < PAGE_WORDS; gi++) begin : g_word
      assign words[gi] = page_q[gi*BUS_W +: BUS_W];
    end
  endgenerate

  assign word_out = words[sel];

endmodule

// File: rtl/fmx_prot_ctrl.sv
`timescale 1ns/1ps
module fmx_prot_ctrl
  import flash_mux_pkg::*;
#(
  parameter int NBLK = 8
) (
  input  logic                     clk,
  input  logic                     rst_any,
  input  logic                     cmd_stb,
  input  logic [7:0]               cmd_code,
  input  logic [$clog2(NBLK)-1:0]  blk,
  input  logic                     wprot_n,
  output logic [NBLK-1:0]          blk_prot,
  output logic [NBLK-1:0]          blk_lock,
  output rd_mode_e                 rd_mode
);

  logic unprot_ok;

  assign unprot_ok = ~blk_lock[blk] | wprot_n;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      blk_prot <= '1;
      blk_lock <= '0;
      rd_mode  <= MODE_ARRAY;
    end else if (cmd_stb) begin
      case (cmd_code)
        CMD_READ_ARRAY: rd_mode <= MODE_ARRAY;
        CMD_IDENT:      rd_mode <= MODE_IDENT;
        CMD_PROTECT:    blk_prot[blk] <= 1'b1;
        CMD_UNPROTECT:  if (unprot_ok) blk_prot[blk] <= 1'b0;
        CMD_LOCK:       blk_lock[blk] <= 1'b1;
        default:        ;
      endcase
    end
  end

endmodule

// File: rtl/flash_mux_rd.sv
`timescale 1ns/1ps
module flash_mux_rd
  import flash_mux_pkg::*;
#(
  parameter int          BUS_W      = 16,
  parameter int          AW         = 10,
  parameter int          NBLK       = 8,
  parameter int          PAGE_WORDS = 4,
  parameter logic [15:0] MFR_ID     = 16'h0020,
  parameter logic [15:0] DEV_ID     = 16'h7E41
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic             adv_n,
  input  logic             pwrdn_n,
  input  logic             wprot_n,
  input  logic [BUS_W-1:0] ad_i,
  output logic [BUS_W-1:0] ad_o,
  output logic             ad_oe
);

  localparam int OFS_W = $clog2(PAGE_WORDS);
  localparam int BLK_W = $clog2(NBLK);

  logic                rst_any;
  logic [AW-1:0]       lat_addr;
  logic                lat_stb;
  logic                cmd_stb;
  logic [BUS_W-1:0]    page_word;
  logic [NBLK-1:0]     blk_prot;
  logic [NBLK-1:0]     blk_lock;
  rd_mode_e            rd_mode;
  logic [BLK_W-1:0]    blk_idx;
  logic [BUS_W-1:0]    ident_word;
  logic [BUS_W-1:0]    rd_word;
  logic                drive;
  logic                unused_hi;

  assign rst_any   = rst | ~pwrdn_n;
  assign blk_idx   = lat_addr[AW-1 -: BLK_W];
  assign unused_hi = ^ad_i[BUS_W-1:AW];

  fmx_bus_sampler #(.AW(AW)) u_sampler (
    .clk      (clk),
    .rst_any  (rst_any),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .adv_n    (adv_n),
    .addr_in  (ad_i[AW-1:0]),
    .lat_addr (lat_addr),
    .lat_stb  (lat_stb),
    .cmd_stb  (cmd_stb)
  );

  fmx_page_store #(.AW(AW), .BUS_W(BUS_W), .PAGE_WORDS(PAGE_WORDS)) u_page (
    .clk      (clk),
    .rst_any  (rst_any),
    .ld       (lat_stb),
    .ld_page  (ad_i[AW-1:OFS_W]),
    .sel      (lat_addr[OFS_W-1:0]),
    .word_out (page_word)
  );

  fmx_prot_ctrl #(.NBLK(NBLK)) u_prot (
    .clk      (clk),
    .rst_any  (rst_any),
    .cmd_stb  (cmd_stb),
    .cmd_code (ad_i[7:0]),
    .blk      (blk_idx),
    .wprot_n  (wprot_n),
    .blk_prot (blk_prot),
    .blk_lock (blk_lock),
    .rd_mode  (rd_mode)
  );

  // Identifier space: direct decode, never through the page buffer
  always_comb begin
    ident_word = '0;
    case (lat_addr[1:0])
      2'd0: ident_word = BUS_W'(MFR_ID);
      2'd1: ident_word = BUS_W'(DEV_ID);
      2'd2: begin
        ident_word[0] = blk_prot[blk_idx];
        ident_word[1] = blk_lock[blk_idx];
      end
      default: ident_word = '0;
    endcase
  end

  assign rd_word = (rd_mode == MODE_IDENT) ? ident_word : page_word;
  assign drive   = ~ce_n & ~oe_n;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      ad_oe <= 1'b0;
      ad_o  <= '0;
    end else begin
      ad_oe <= drive;
      ad_o  <= drive ? rd_word : '0;
    end
  end

endmodule

// File: rtl/flash_mux_rd_chk.sv
`timescale 1ns/1ps
module flash_mux_rd_chk
  import flash_mux_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int NBLK  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             pwrdn_n,
  input logic             ce_n,
  input logic             oe_n,
  input logic             wprot_n,
  input logic             ad_oe,
  input logic [BUS_W-1:0] ad_o,
  input logic [NBLK-1:0]  blk_prot,
  input logic [NBLK-1:0]  blk_lock,
  input rd_mode_e         rd_mode
);

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !ad_oe |-> ad_o == '0);

  p_bus_on_r4: assert property (@(posedge clk) disable iff (rst)
    (pwrdn_n && !ce_n && !oe_n) |=> ad_oe);

  p_bus_off_r4: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n || !pwrdn_n) |=> !ad_oe);

  p_pd_state_r10: assert property (@(posedge clk) disable iff (rst)
    !pwrdn_n |=> (rd_mode == MODE_ARRAY && (&blk_prot) && blk_lock == '0));

  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    pwrdn_n |=> ((blk_lock & $past(blk_lock)) == $past(blk_lock)));

  p_wp_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (|($past(blk_prot) & ~blk_prot & $past(blk_lock))) |-> $past(wprot_n));

endmodule

bind flash_mux_rd flash_mux_rd_chk #(.BUS_W(BUS_W), .NBLK(NBLK)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwrdn_n  (pwrdn_n),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .wprot_n  (wprot_n),
  .ad_oe    (ad_oe),
  .ad_o     (ad_o),
  .blk_prot (blk_prot),
  .blk_lock (blk_lock),
  .rd_mode  (rd_mode)
);

// File: tb/flash_mux_rd_tb_top.sv
`timescale 1ns/1ps
module flash_mux_rd_tb_top;

  localparam int          AW   = 10;
  localparam int          NB   = 8;
  localparam int          BW   = 3;
  localparam logic [15:0] DEVC = 16'h7E41;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, adv_n = 1'b1;
  logic        pwrdn_n = 1'b1, wprot_n = 1'b1;
  logic [15:0] ad_i = '0;
  logic [15:0] ad_o;
  logic        ad_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_mux_rd dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .adv_n(adv_n), .pwrdn_n(pwrdn_n), .wprot_n(wprot_n),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe)
  );

  function automatic logic [15:0] wd(input int a);
    logic [31:0] p;
    p = 32'(a) * 32'd40503;
    return p[15:0] ^ 16'h5A3C;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference, evaluated at every rising edge
  bit          m_prot [NB];
  bit          m_lock [NB];
  bit          m_ident, m_advq, m_weq, started;
  int          m_lat;
  logic        e_oe;
  logic [15:0] e_do;
  string       e_tag;

  always @(posedge clk) begin
    int blk;
    logic [15:0] rd;
    started = 1;
    if (rst || !pwrdn_n) begin
      foreach (m_prot[i]) begin m_prot[i] = 1; m_lock[i] = 0; end
      m_ident = 0; m_advq = 1; m_weq = 1; m_lat = 0;
      e_oe = 0; e_do = 0; e_tag = "R10";
    end else begin
      blk = (m_lat >> (AW - BW)) % NB;
      if (m_ident) begin
        e_tag = "R5";
        case (m_lat % 4)
          0: rd = 16'h0020;
          1: rd = DEVC;
          2: rd = {14'd0, m_lock[blk], m_prot[blk]};
          default: rd = 16'h0000;
        endcase
      end else begin
        e_tag = "R3";
        rd = wd(m_lat);
      end
      e_oe = !ce_n && !oe_n;
      e_do = e_oe ? rd : 16'h0000;
      if (!we_n && m_weq && !ce_n && oe_n) begin
        case (ad_i[7:0])
          8'hFF: m_ident = 0;
          8'h90: m_ident = 1;
          8'h01: m_prot[blk] = 1;
          8'hD0: if (!m_lock[blk] || wprot_n) m_prot[blk] = 0;
          8'h2F: m_lock[blk] = 1;
          default: ;
        endcase
      end
      if (adv_n && !m_advq && !ce_n) m_lat = int'(ad_i) % (1 << AW);
      m_advq = adv_n;
      m_weq  = we_n;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check("R4 model bus enable", {15'd0, ad_oe}, {15'd0, e_oe});
      check({e_tag, " model data"}, ad_o, e_do);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch(input logic [15:0] a);
    ce_n = 0; adv_n = 0; ad_i = a;
    tick(1);
    adv_n = 1;
    tick(1);
    ad_i = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] exp);
    ce_n = 0; oe_n = 0;
    tick(2);
    check(tag, ad_o, exp);
    check(tag, {15'd0, ad_oe}, 16'd1);
    oe_n = 1;
    tick(1);
  endtask

  task automatic cmd(input logic [7:0] c);
    oe_n = 1; ce_n = 0; we_n = 0; ad_i = {8'h00, c};
    tick(1);
    we_n = 1; ad_i = '0;
    tick(1);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    check("R10 bus off in reset", {15'd0, ad_oe}, 16'd0);
    rst = 0;
    // R4: standby with output enable low
    ce_n = 1; oe_n = 0;
    tick(2);
    check("R4 standby bus off", {15'd0, ad_oe}, 16'd0);
    oe_n = 1;
    // R10: array mode after reset, address 0
    rd_chk("R10 reset address array word", wd(0));
    // R3 / R2: page word selection
    latch(16'h0105);
    rd_chk("R3 array read 105", wd(16'h105));
    for (int o = 0; o < 4; o++) begin
      latch(16'h0104 | 16'(o));
      rd_chk("R3 page offset", wd(16'h104 + o));
    end
    // R1: upper bus bits ignored
    latch(16'hFC05);
    rd_chk("R1 upper bits dropped", wd(16'h005));
    // R1: strobe rise with chip disabled does not latch
    ce_n = 1; adv_n = 0; ad_i = 16'h0200; tick(1); adv_n = 1; tick(1);
    rd_chk("R1 latch gated by ce_n", wd(16'h005));
    // R4: output enable high while selected
    ce_n = 0; oe_n = 1; tick(2);
    check("R4 oe_n high bus off", {15'd0, ad_oe}, 16'd0);
    check("R4 data zero when off", ad_o, 16'h0000);
    // R5: identifier reads
    cmd(8'h90);
    latch(16'h0000); rd_chk("R5 manufacturer code", 16'h0020);
    latch(16'h0001); rd_chk("R5 device code", DEVC);
    latch(16'h0003); rd_chk("R5 reserved offset", 16'h0000);
    // R6: block status of block 5
    latch(16'((5 << 7) | 2)); rd_chk("R6 default status", 16'h0001);
    cmd(8'h2F);               rd_chk("R6 locked status", 16'h0003);
    wprot_n = 0; cmd(8'hD0);  rd_chk("R8 locked unprotect blocked", 16'h0003);
    wprot_n = 1; cmd(8'hD0);  rd_chk("R8 locked unprotect with wp high", 16'h0002);
    cmd(8'h01);               rd_chk("R7 protect", 16'h0003);
    cmd(8'h55);               rd_chk("R7 unknown code ignored", 16'h0003);
    cmd(8'hD0); cmd(8'h60); cmd(8'h00);
    rd_chk("R9 lock survives commands", 16'h0002);
    // R8: unlocked block ignores write protect
    wprot_n = 0;
    latch(16'((2 << 7) | 2)); rd_chk("R6 block 2 default", 16'h0001);
    cmd(8'hD0);               rd_chk("R8 unlocked unprotect wp low", 16'h0000);
    wprot_n = 1;
    // R7: back to array mode
    cmd(8'hFF);
    latch(16'h0105); rd_chk("R7 array mode restored", wd(16'h105));
    // R10: power-down releases bus and restores state
    cmd(8'h90);
    ce_n = 0; oe_n = 0; pwrdn_n = 0; tick(3);
    check("R10 bus off in power-down", {15'd0, ad_oe}, 16'd0);
    pwrdn_n = 1; tick(2);
    check("R10 array word after power-down", ad_o, wd(0));
    oe_n = 1; tick(1);
    cmd(8'h90);
    latch(16'((5 << 7) | 2)); rd_chk("R10 lock cleared by power-down", 16'h0001);
    tick(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule